// File: doc/BRIEF.md
# Decimal floating-point result normalizer

This block sits between a decimal arithmetic datapath and its rounder. It accepts an intermediate result with a double-width significand of BCD digits, a two's-complement exponent and class flags. The two most significant digits of that significand are integer digits and the rest are fractional. The block moves the significand by whole decimal digits so that the single integer digit of the result is nonzero, and corrects the exponent by the same number of digits. The exponent is never allowed below a programmable floor: when that floor binds, the result is left unnormalized. When the input has already underflowed, the significand is moved right instead. The result is narrowed to the working precision plus one guard digit, and every nonzero digit that falls off the bottom is folded into one sticky bit.

NaNs, infinities and zero significands are not normalized. They keep their exponent and their digit alignment. The class flags and the sign ride alongside the value. A result appears two clock cycles after its input, marked by a valid strobe, and a new input can be accepted every cycle.

Top module: `dfp_normalizer`

## Requirements
- R1: `out_valid` is high in the cycle exactly two clock cycles after a cycle with `in_valid` high, and is low otherwise, including while reset is applied.
- R2: `out_nan`, `out_qnan`, `out_snan`, `out_inf` and `out_sign` equal the matching inputs of the cycle that produced the result.
- R3: BCD digit i occupies bits 4i+3..4i. For an alignment k, output digit j (j = 0..DIG_OUT-1) equals input digit j + DIG_IN - DIG_OUT - k, or zero when that index lies outside the input. The top output digit is the integer digit. Exponents are two's complement and EXP_MIN = -400 by default.
- R4: When `in_nan` or `in_inf` is set, k = 1, so input digit DIG_IN-2 lands on the top output digit. The exponent is passed unchanged.
- R5: An all-zero input significand gives an all-zero output significand, a clear sticky bit and an unchanged exponent.
- R6: When the top input digit is nonzero, k = 0. This is a one-digit right move, and the exponent rises by one.
- R7: With L leading zero digits (L ≥ 1) and e+1-L ≥ EXP_MIN, k = L. The exponent becomes e+1-L and the top output digit is nonzero.
- R8: When e ≥ EXP_MIN but e+1-L < EXP_MIN, k = e+1-EXP_MIN and the exponent becomes EXP_MIN.
- R9: When e < EXP_MIN (underflow), k = e+1-EXP_MIN ≤ 0, which is a right move, and the exponent becomes EXP_MIN. A move past the whole input leaves zero digits, and every nonzero input digit then goes into the sticky bit.
- R10: `out_sticky` is the OR of all input digits whose index is below DIG_IN - DIG_OUT - k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present this cycle |
| in_nan | input | 1 | Input is a NaN |
| in_qnan | input | 1 | Input is a quiet NaN |
| in_snan | input | 1 | Input is a signalling NaN |
| in_inf | input | 1 | Input is an infinity |
| in_sign | input | 1 | Input sign |
| in_exp | input | EXP_W | Input exponent, two's complement |
| in_sig | input | DIG_IN*4 | Input BCD significand, two integer digits on top |
| out_valid | output | 1 | Result present this cycle |
| out_nan | output | 1 | NaN flag of the result |
| out_qnan | output | 1 | Quiet-NaN flag of the result |
| out_snan | output | 1 | Signalling-NaN flag of the result |
| out_inf | output | 1 | Infinity flag of the result |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Result exponent, two's complement |
| out_sig | output | DIG_OUT*4 | Result BCD significand, one integer digit on top |
| out_sticky | output | 1 | OR of all discarded input digits |

## Verification
The bench uses the defaults: 32 input digits, 17 output digits, a 10-bit exponent and EXP_MIN = -400. With these values the exponent can sit more than 32 digits below the floor, so a right move that empties the whole significand into the sticky bit can be reached. The floor also lies close enough to ordinary values that the limited left move of R8 appears in both random and directed vectors. Streams with gaps and back-to-back inputs exercise the two-cycle timing, and the stimulus covers every leading-zero count from none to an all-zero significand.

// File: rtl/dfp_norm_pkg.sv
package dfp_norm_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef struct packed {
    logic nan;
    logic qnan;
    logic snan;
    logic inf;
    logic sign;
  } dfpn_flags_t;

  function automatic logic digit_nonzero(input logic [DIGIT_W-1:0] d);
    return |d;
  endfunction

endpackage

// File: rtl/dfp_norm_lzc.sv
module dfp_norm_lzc
  import dfp_norm_pkg::*;
#(
  parameter int unsigned NDIG = 32,
  localparam int unsigned CW = $clog2(NDIG + 1)
) (
  input  logic [NDIG*DIGIT_W-1:0] sig_i,
  output logic [CW-1:0]           lz_o,
  output logic                    zero_o
);

  logic [NDIG-1:0] nz;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign nz[g] = digit_nonzero(sig_i[g*DIGIT_W +: DIGIT_W]);
  end

  // highest nonzero digit wins; scan upward so the last hit is the top one
  always_comb begin
    lz_o = CW'(NDIG);
    for (int i = 0; i < int'(NDIG); i++) begin
      if (nz[i]) lz_o = CW'(int'(NDIG) - 1 - i);
    end
  end

  assign zero_o = ~|nz;

endmodule

// File: rtl/dfp_norm_ctl.sv
module dfp_norm_ctl
  import dfp_norm_pkg::*;
#(
  parameter int unsigned NDIG    = 32,
  parameter int unsigned EXP_W   = 10,
  parameter int          EXP_MIN = -400,
  localparam int unsigned CW = $clog2(NDIG + 1),
  localparam int unsigned AW = $clog2(2*NDIG + 1)
) (
  input  dfpn_flags_t      flags_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CW-1:0]    lz_i,
  input  logic             zero_i,
  output logic [AW-1:0]    amt_o,
  output logic [EXP_W-1:0] exp_o
);

  int e_in;
  int room;
  int align;
  int e_out;

  // align = digit alignment k; amt = right move of the padded vector
  always_comb begin
    e_in = int'($signed(exp_i));
    room = e_in + 1 - EXP_MIN;
    if (flags_i.nan || flags_i.inf || zero_i) begin
      align = 1;
      e_out = e_in;
    end else if (room < int'(lz_i)) begin
      align = room;
      e_out = EXP_MIN;
    end else begin
      align = int'(lz_i);
      e_out = e_in + 1 - align;
    end
    if (align < -int'(NDIG)) align = -int'(NDIG);
    amt_o = AW'(int'(NDIG) - align);
    exp_o = EXP_W'(e_out);
  end

endmodule

// File: rtl/dfp_norm_align.sv
module dfp_norm_align
  import dfp_norm_pkg::*;
#(
  parameter int unsigned NDIG_IN  = 32,
  parameter int unsigned NDIG_OUT = 17,
  localparam int unsigned AW = $clog2(2*NDIG_IN + 1),
  localparam int unsigned VW = (NDIG_IN + NDIG_OUT) * DIGIT_W
) (
  input  logic [NDIG_IN*DIGIT_W-1:0]  sig_i,
  input  logic [AW-1:0]               amt_i,
  output logic [NDIG_OUT*DIGIT_W-1:0] sig_o,
  output logic                        sticky_o
);

  logic [VW-1:0] stg [AW+1];
  logic [AW:0]   stk;

  assign stg[0] = {sig_i, {(NDIG_OUT*DIGIT_W){1'b0}}};
  assign stk[0] = 1'b0;

  // log-depth digit shifter; each stage ORs what it drops into sticky
  for (genvar g = 0; g < AW; g++) begin : g_stage
    localparam int unsigned SH = (2**g) * DIGIT_W;
    if (SH >= VW) begin : g_all
      assign stg[g+1] = amt_i[g] ? '0 : stg[g];
      assign stk[g+1] = stk[g] | (amt_i[g] & (|stg[g]));
    end else begin : g_part
      assign stg[g+1] = amt_i[g] ? (stg[g] >> SH) : stg[g];
      assign stk[g+1] = stk[g] | (amt_i[g] & (|stg[g][SH-1:0]));
    end
  end

  assign sig_o    = stg[AW][NDIG_OUT*DIGIT_W-1:0];
  assign sticky_o = stk[AW];

endmodule

// File: rtl/dfp_normalizer.sv
module dfp_normalizer
  import dfp_norm_pkg::*;
#(
  parameter int unsigned DIG_IN  = 32,
  parameter int unsigned DIG_OUT = 17,
  parameter int unsigned EXP_W   = 10,
  parameter int          EXP_MIN = -400
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_nan,
  input  logic                       in_qnan,
  input  logic                       in_snan,
  input  logic                       in_inf,
  input  logic                       in_sign,
  input  logic [EXP_W-1:0]           in_exp,
  input  logic [DIG_IN*DIGIT_W-1:0]  in_sig,
  output logic                       out_valid,
  output logic                       out_nan,
  output logic                       out_qnan,
  output logic                       out_snan,
  output logic                       out_inf,
  output logic                       out_sign,
  output logic [EXP_W-1:0]           out_exp,
  output logic [DIG_OUT*DIGIT_W-1:0] out_sig,
  output logic                       out_sticky
);

  localparam int unsigned SIG_IN_W  = DIG_IN * DIGIT_W;
  localparam int unsigned SIG_OUT_W = DIG_OUT * DIGIT_W;
  localparam int unsigned LZ_W      = $clog2(DIG_IN + 1);
  localparam int unsigned AMT_W     = $clog2(2*DIG_IN + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // stage 1: leading-zero count and move decision
  dfpn_flags_t      in_flags;
  logic [LZ_W-1:0]  lz;
  logic             sig_zero;
  logic [AMT_W-1:0] ctl_amt;
  logic [EXP_W-1:0] ctl_exp;

  assign in_flags = '{nan: in_nan, qnan: in_qnan, snan: in_snan,
                      inf: in_inf, sign: in_sign};

  dfp_norm_lzc #(.NDIG(DIG_IN)) u_lzc (
    .sig_i  (in_sig),
    .lz_o   (lz),
    .zero_o (sig_zero)
  );

  dfp_norm_ctl #(.NDIG(DIG_IN), .EXP_W(EXP_W), .EXP_MIN(EXP_MIN)) u_ctl (
    .flags_i (in_flags),
    .exp_i   (in_exp),
    .lz_i    (lz),
    .zero_i  (sig_zero),
    .amt_o   (ctl_amt),
    .exp_o   (ctl_exp)
  );

  logic                s1_v;
  dfpn_flags_t         s1_flags, s1_flags_d;
  logic [EXP_W-1:0]    s1_exp,   s1_exp_d;
  logic [AMT_W-1:0]    s1_amt,   s1_amt_d;
  logic [SIG_IN_W-1:0] s1_sig,   s1_sig_d;

  always_comb begin
    s1_flags_d = s1_flags;
    s1_exp_d   = s1_exp;
    s1_amt_d   = s1_amt;
    s1_sig_d   = s1_sig;
    if (in_valid) begin
      s1_flags_d = in_flags;
      s1_exp_d   = ctl_exp;
      s1_amt_d   = ctl_amt;
      s1_sig_d   = in_sig;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) s1_v <= 1'b0;
    else          s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_flags <= s1_flags_d;
    s1_exp   <= s1_exp_d;
    s1_amt   <= s1_amt_d;
    s1_sig   <= s1_sig_d;
  end

  // stage 2: digit move and sticky fold
  logic [SIG_OUT_W-1:0] al_sig;
  logic                 al_sticky;

  dfp_norm_align #(.NDIG_IN(DIG_IN), .NDIG_OUT(DIG_OUT)) u_align (
    .sig_i    (s1_sig),
    .amt_i    (s1_amt),
    .sig_o    (al_sig),
    .sticky_o (al_sticky)
  );

  dfpn_flags_t          o_flags, o_flags_d;
  logic [EXP_W-1:0]     o_exp,   o_exp_d;
  logic [SIG_OUT_W-1:0] o_sig,   o_sig_d;
  logic                 o_stk,   o_stk_d;
  logic                 o_v;

  always_comb begin
    o_flags_d = o_flags;
    o_exp_d   = o_exp;
    o_sig_d   = o_sig;
    o_stk_d   = o_stk;
    if (s1_v) begin
      o_flags_d = s1_flags;
      o_exp_d   = s1_exp;
      o_sig_d   = al_sig;
      o_stk_d   = al_sticky;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) o_v <= 1'b0;
    else          o_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    o_flags <= o_flags_d;
    o_exp   <= o_exp_d;
    o_sig   <= o_sig_d;
    o_stk   <= o_stk_d;
  end

  assign out_valid  = o_v;
  assign out_nan    = o_flags.nan;
  assign out_qnan   = o_flags.qnan;
  assign out_snan   = o_flags.snan;
  assign out_inf    = o_flags.inf;
  assign out_sign   = o_flags.sign;
  assign out_exp    = o_exp;
  assign out_sig    = o_sig;
  assign out_sticky = o_stk;

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == $past(in_valid, 2));

  // R2
  flag_align_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> (out_sign == $past(in_sign, 2)) && (out_nan == $past(in_nan, 2))
                  && (out_inf == $past(in_inf, 2)) && (out_qnan == $past(in_qnan, 2))
                  && (out_snan == $past(in_snan, 2)));

  // R4
  special_exp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && (out_nan || out_inf) |-> out_exp == $past(in_exp, 2));

  // R5
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && !(out_nan || out_inf) && ($past(in_sig, 2) == '0)
      |-> (out_sig == '0) && !out_sticky && (out_exp == $past(in_exp, 2)));

  // R7
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && !(out_nan || out_inf) && ($signed(out_exp) != EXP_MIN) && (out_sig != '0)
      |-> out_sig[SIG_OUT_W-1 -: DIGIT_W] != '0);

  // R8
  exp_floor_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid && !(out_nan || out_inf) && ($signed($past(in_exp, 2)) >= EXP_MIN)
      |-> $signed(out_exp) >= EXP_MIN);

endmodule

// File: tb/dfp_normalizer_test.sv
module dfp_normalizer_test;

  localparam int DIN   = 32;
  localparam int DOUT  = 17;
  localparam int EW    = 10;
  localparam int EMIN  = -400;
  localparam int SINW  = DIN * 4;
  localparam int SOUTW = DOUT * 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, in_nan, in_qnan, in_snan, in_inf, in_sign;
  logic [EW-1:0]   in_exp;
  logic [SINW-1:0] in_sig;
  logic            out_valid, out_nan, out_qnan, out_snan, out_inf, out_sign;
  logic [EW-1:0]   out_exp;
  logic [SOUTW-1:0] out_sig;
  logic            out_sticky;

  always #5 clk = ~clk;

  dfp_normalizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_nan(in_nan), .in_qnan(in_qnan), .in_snan(in_snan), .in_inf(in_inf),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .out_valid(out_valid), .out_nan(out_nan), .out_qnan(out_qnan),
    .out_snan(out_snan), .out_inf(out_inf), .out_sign(out_sign),
    .out_exp(out_exp), .out_sig(out_sig), .out_sticky(out_sticky)
  );

  typedef struct {
    logic             v;
    logic [4:0]       fl;
    int               e;
    logic [SOUTW-1:0] s;
    logic             st;
    string            tag;
  } exp_t;

  exp_t hist [2];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // expected result from the requirement text, digit by digit
  task automatic model(input logic [SINW-1:0] sig, input int e, input logic spec,
                       output logic [SOUTW-1:0] osig, output logic ost,
                       output int oe, output string tag);
    int d [DIN];
    int lz, k, room;
    bit hit;
    for (int i = 0; i < DIN; i++) d[i] = int'(sig[4*i +: 4]);
    lz = DIN;
    hit = 0;
    for (int i = DIN - 1; i >= 0; i--) begin
      if (!hit && d[i] != 0) begin lz = DIN - 1 - i; hit = 1; end
    end
    room = e + 1 - EMIN;
    if (spec)               begin k = 1;    oe = e;        tag = "R4"; end
    else if (lz == DIN)     begin k = 1;    oe = e;        tag = "R5"; end
    else if (e < EMIN)      begin k = room; oe = EMIN;     tag = "R9"; end
    else if (lz > room)     begin k = room; oe = EMIN;     tag = "R8"; end
    else if (lz == 0)       begin k = 0;    oe = e + 1;    tag = "R6"; end
    else                    begin k = lz;   oe = e + 1 - lz; tag = "R7"; end
    osig = '0;
    ost  = 1'b0;
    for (int j = 0; j < DOUT; j++) begin
      int src;
      src = j + DIN - DOUT - k;
      if (src >= 0 && src < DIN) osig[4*j +: 4] = 4'(d[src]);
    end
    for (int i = 0; i < DIN; i++) begin
      if (i < DIN - DOUT - k && d[i] != 0) ost = 1'b1;
    end
  endtask

  task automatic check(input exp_t h);
    n_vec++;
    if (out_valid !== h.v) begin
      n_fail++;
      $display("FAIL R1 out_valid got %b expected %b", out_valid, h.v);
    end else if (h.v) begin
      if ({out_nan, out_qnan, out_snan, out_inf, out_sign} !== h.fl) begin
        n_fail++;
        $display("FAIL R2 flags got %b expected %b",
                 {out_nan, out_qnan, out_snan, out_inf, out_sign}, h.fl);
      end
      if (out_sig !== h.s) begin
        n_fail++;
        $display("FAIL %s/R3 sig got %h expected %h", h.tag, out_sig, h.s);
      end
      if (out_exp !== EW'(h.e)) begin
        n_fail++;
        $display("FAIL %s exp got %0d expected %0d", h.tag, $signed(out_exp), h.e);
      end
      if (out_sticky !== h.st) begin
        n_fail++;
        $display("FAIL R10 (%s) sticky got %b expected %b", h.tag, out_sticky, h.st);
      end
    end
  endtask

  task automatic step(input logic v, input logic [4:0] fl, input int e,
                      input logic [SINW-1:0] sig);
    exp_t nx;
    @(negedge clk);
    check(hist[1]);
    hist[1] = hist[0];
    nx.v  = v;
    nx.fl = fl;
    model(sig, e, fl[4] | fl[1], nx.s, nx.st, nx.e, nx.tag);
    hist[0] = nx;
    in_valid = v;
    {in_nan, in_qnan, in_snan, in_inf, in_sign} = fl;
    in_exp = EW'(e);
    in_sig = sig;
  endtask

  function automatic logic [SINW-1:0] rand_sig();
    logic [SINW-1:0] s;
    int lz, tz;
    lz = int'($urandom_range(0, DIN));
    tz = ($urandom % 3 == 0) ? int'($urandom_range(0, DIN)) : 0;
    s = '0;
    for (int i = DIN - 1; i >= 0; i--) begin
      int pos;
      pos = DIN - 1 - i;
      if (pos < lz || i < tz) s[4*i +: 4] = 4'd0;
      else if (pos == lz)     s[4*i +: 4] = 4'(1 + $urandom % 9);
      else                    s[4*i +: 4] = 4'($urandom % 10);
    end
    return s;
  endfunction

  function automatic int rand_exp();
    int sel;
    sel = int'($urandom % 10);
    if (sel < 4)      return -512 + int'($urandom_range(0, 1022));
    else if (sel < 8) return EMIN - 40 + int'($urandom_range(0, 80));
    else              return -50 + int'($urandom_range(0, 100));
  endfunction

  function automatic logic [4:0] rand_flags();
    logic [4:0] f;
    int sel;
    sel = int'($urandom % 16);
    f = '0;
    f[0] = 1'($urandom % 2);
    if (sel == 0)      begin f[4] = 1'b1; f[3] = 1'b1; end
    else if (sel == 1) begin f[4] = 1'b1; f[2] = 1'b1; end
    else if (sel == 2) f[1] = 1'b1;
    return f;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    hist[0] = '{v: 1'b0, fl: '0, e: 0, s: '0, st: 1'b0, tag: "R1"};
    hist[1] = hist[0];
    rst_n = 1'b0;
    in_valid = 1'b0;
    {in_nan, in_qnan, in_snan, in_inf, in_sign} = '0;
    in_exp = '0;
    in_sig = '0;
    // R1: out_valid held low through reset and its release
    for (int i = 0; i < 4; i++) step(1'b0, 5'b0, 0, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 5'b0, 0, '0);

    // R5 zero significand
    step(1'b1, 5'b00000, 17, '0);
    step(1'b1, 5'b00001, -450, '0);
    // R4 quiet NaN with top digit set, and an infinity
    step(1'b1, 5'b11000, 5, 128'h73000000_00000000_00000000_00000001);
    step(1'b1, 5'b00011, -3, 128'h00000000_00000000_00000000_00000042);
    // R6 top digit nonzero
    step(1'b1, 5'b00000, 100, 128'h98765432_10987654_32109876_54321098);
    // R7 already normalized and maximal leading zeros
    step(1'b1, 5'b00001, 0, 128'h05000000_00000000_00000000_00000000);
    step(1'b1, 5'b00000, 200, 128'h00000000_00000000_00000000_00000003);
    // R8 left move limited by the floor
    step(1'b1, 5'b00000, -395, 128'h00000000_00123456_78901234_56789012);
    // R9 underflow: small right move, then everything shifted out
    step(1'b1, 5'b00000, -405, 128'h01234567_89012345_67890123_45678901);
    step(1'b1, 5'b00001, -512, 128'h12345678_90123456_78901234_56789012);
    // R10 sticky clear when nothing below the window, set by one low digit
    step(1'b1, 5'b00000, 10, 128'h01234567_89123456_78000000_00000000);
    step(1'b1, 5'b00000, 10, 128'h01000000_00000000_00000000_00000001);
    step(1'b0, 5'b0, 0, '0);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, rand_flags(), rand_exp(), rand_sig());
    end
    for (int i = 0; i < 3; i++) step(1'b0, 5'b0, 0, '0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule